// File: doc/BRIEF.md
# Masked Repeating Alarm Unit

This block watches a running BCD time and date, supplied on its inputs by a separate timekeeper, and raises a one-cycle alarm event whenever the digits selected by a 4-bit interval code match a stored alarm stamp. The interval code selects the match rate. It can fire on every half-second strobe or every second strobe. It can compare a growing set of digits to fire every ten seconds, every minute, every ten minutes, every hour, every day, every week, every month or every year. Matching is evaluated only when the relevant strobe is present, so one match produces exactly one event.

A configuration load sets the enable, the chime mode, the interval code and an 8-bit repeat count. Each event decrements the repeat count. Without chime, the event that finds the count at zero is the last one, and the unit then disables itself. With chime, the count wraps and the alarm keeps running. A toggle output flips once per event and gives a square wave at half the event rate. A select input drives the output pin either from that toggle or from a seconds square wave built from the strobes.

The control is a three-state machine with the states OFF, ARMED and FIRE. Its transitions are:
- OFF to ARMED on a load with the enable set.
- ARMED to FIRE on a strobed match.
- FIRE back to ARMED while repeats remain or chime is set.
- FIRE to OFF when the repeats are used up.

From any state, a device reset goes to OFF and a load goes to ARMED or OFF.

Top module: `alarm_unit`

## Requirements
- R1: After power-on reset (rst_n low), alm_en, alm_evt, alm_tgl, sec_clk, alm_pin and rpt_cnt are all 0.
- R2: Interval codes select the compared digits as follows:
  - 0: fire on every half_tick.
  - 1: fire on every sec_tick.
  - 2: seconds ones digit.
  - 3: both seconds digits.
  - 4: adds the minutes ones digit.
  - 5: adds the minutes tens digit.
  - 6: adds the hour.
  - 7: adds the weekday.
  - 8: hours, minutes, seconds and day of month.
  - 9: code 8 plus the month.
  
  Codes 2 to 9 are evaluated on sec_tick.
- R3: Interval codes 10 to 15 never produce an event.
- R4: A strobed match in ARMED gives alm_evt high for exactly one cycle, the cycle after the strobe is sampled.
- R5: Each event decrements rpt_cnt. An event that finds rpt_cnt at 0 with chime clear is the last one: alm_en falls after it and rpt_cnt stays 0.
- R6: With chime set, an event at rpt_cnt 0 wraps the count to FFh and alm_en stays 1.
- R7: alm_tgl inverts in the cycle after each event and holds otherwise.
- R8: sec_clk falls on sec_tick and rises on a half_tick without sec_tick. alm_pin equals sec_clk when pin_sel is 1 and alm_tgl when pin_sel is 0.
- R9: dev_rst clears alm_en, rpt_cnt, the chime bit and the code in the next cycle, and leaves alm_tgl unchanged.
- R10: cfg_wr loads the enable, chime, code and rpt_cnt in one cycle. It overrides both an event update and a match.
- R11: Under code 9, an alarm set to month 02 day 29 fires only when the current date is 02/29.
- R12: While alm_en is 0, no event occurs whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| dev_rst | input | 1 | Device reset, synchronous; disables the alarm |
| cfg_wr | input | 1 | Load strobe for the configuration |
| cfg_en | input | 1 | Enable value to load |
| cfg_chime | input | 1 | Chime value to load |
| cfg_code | input | 4 | Interval code to load |
| cfg_rpt | input | 8 | Repeat count to load |
| half_tick | input | 1 | Half-second strobe, one cycle |
| sec_tick | input | 1 | Whole-second strobe, asserted together with half_tick |
| t_sec | input | 8 | Current seconds, BCD |
| t_min | input | 8 | Current minutes, BCD |
| t_hour | input | 8 | Current hour, BCD |
| t_wday | input | 8 | Current weekday 0..6 |
| t_day | input | 8 | Current day of month, BCD |
| t_mon | input | 8 | Current month, BCD |
| a_sec | input | 8 | Alarm seconds, BCD |
| a_min | input | 8 | Alarm minutes, BCD |
| a_hour | input | 8 | Alarm hour, BCD |
| a_wday | input | 8 | Alarm weekday |
| a_day | input | 8 | Alarm day of month, BCD |
| a_mon | input | 8 | Alarm month, BCD |
| pin_sel | input | 1 | Output pin source: 1 = seconds clock, 0 = alarm toggle |
| alm_evt | output | 1 | One-cycle alarm event |
| alm_en | output | 1 | Alarm enabled (state is not OFF) |
| rpt_cnt | output | 8 | Remaining repeat count |
| alm_tgl | output | 1 | Toggles once per event |
| sec_clk | output | 1 | Seconds square wave |
| alm_pin | output | 1 | Selected pin output |

## Verification
A wrong digit lane or code decode shows up as an extra or missing alm_evt in the cycle right after the strobe. A stuck FSM state shows on alm_en and alm_evt within one cycle. A counter fault appears on rpt_cnt in the cycle after the event. A wrong exhaustion test shows as alm_en staying high, or falling early, after the final event. The bench's behavioural model predicts every output on every clock, so each of these faults is caught in the first cycle it becomes visible.

// File: rtl/alarm_unit_pkg.sv
package alarm_unit_pkg;

    localparam int FIELD_W = 8;
    localparam int NIB_W   = 4;
    localparam int LANES   = 8;
    localparam int CODE_W  = 4;
    localparam int CODE_MAX = 9;

    // lane order: 0 sec ones, 1 sec tens, 2 min ones, 3 min tens,
    // 4 hour, 5 weekday, 6 day, 7 month
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } alm_state_t;

    typedef struct packed {
        logic [FIELD_W-1:0] mon;
        logic [FIELD_W-1:0] day;
        logic [FIELD_W-1:0] wday;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] sec;
    } stamp_t;

    function automatic logic [LANES-1:0] lanes_for(input logic [CODE_W-1:0] code);
        logic [LANES-1:0] need;
        case (code)
            4'd2:    need = 8'b0000_0001;
            4'd3:    need = 8'b0000_0011;
            4'd4:    need = 8'b0000_0111;
            4'd5:    need = 8'b0000_1111;
            4'd6:    need = 8'b0001_1111;
            4'd7:    need = 8'b0011_1111;
            4'd8:    need = 8'b0101_1111;
            4'd9:    need = 8'b1101_1111;
            default: need = '0;
        endcase
        return need;
    endfunction

    function automatic logic code_ok(input logic [CODE_W-1:0] code);
        return (code <= CODE_W'(CODE_MAX));
    endfunction

endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_unit_pkg::*;
(
    input  stamp_t            now_i,
    input  stamp_t            ref_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              half_tick,
    input  logic              sec_tick,
    output logic              hit_o
);
    logic [FIELD_W-1:0] cur_lane [LANES];
    logic [FIELD_W-1:0] ref_lane [LANES];
    logic [LANES-1:0]   lane_eq;
    logic [LANES-1:0]   need;
    logic               strobe;

    always_comb begin
        cur_lane[0] = {{NIB_W{1'b0}}, now_i.sec[NIB_W-1:0]};
        cur_lane[1] = {{NIB_W{1'b0}}, now_i.sec[FIELD_W-1:NIB_W]};
        cur_lane[2] = {{NIB_W{1'b0}}, now_i.min[NIB_W-1:0]};
        cur_lane[3] = {{NIB_W{1'b0}}, now_i.min[FIELD_W-1:NIB_W]};
        cur_lane[4] = now_i.hour;
        cur_lane[5] = now_i.wday;
        cur_lane[6] = now_i.day;
        cur_lane[7] = now_i.mon;
        ref_lane[0] = {{NIB_W{1'b0}}, ref_i.sec[NIB_W-1:0]};
        ref_lane[1] = {{NIB_W{1'b0}}, ref_i.sec[FIELD_W-1:NIB_W]};
        ref_lane[2] = {{NIB_W{1'b0}}, ref_i.min[NIB_W-1:0]};
        ref_lane[3] = {{NIB_W{1'b0}}, ref_i.min[FIELD_W-1:NIB_W]};
        ref_lane[4] = ref_i.hour;
        ref_lane[5] = ref_i.wday;
        ref_lane[6] = ref_i.day;
        ref_lane[7] = ref_i.mon;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (cur_lane[g] == ref_lane[g]);
    end

    assign need   = lanes_for(code_i);
    assign strobe = (code_i == '0) ? half_tick : sec_tick;
    assign hit_o  = code_ok(code_i) && strobe && (&(lane_eq | ~need));

endmodule

// File: rtl/alarm_repeat.sv
module alarm_repeat #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    input  logic             chime_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             spent_o
);
    logic [CNT_W-1:0] cnt_q;

    assign spent_o = (cnt_q == '0) && !chime_i;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (step_i && !spent_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/alarm_pin.sv
module alarm_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    input  logic sec_tick,
    input  logic flip_i,
    input  logic sel_i,
    output logic tgl_o,
    output logic secclk_o,
    output logic pin_o
);
    logic tgl_q;
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (flip_i) begin
            tgl_q <= ~tgl_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else if (sec_tick) begin
            sclk_q <= 1'b0;
        end else if (half_tick) begin
            sclk_q <= 1'b1;
        end
    end

    assign tgl_o    = tgl_q;
    assign secclk_o = sclk_q;
    assign pin_o    = sel_i ? sclk_q : tgl_q;

endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import alarm_unit_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dev_rst,
    input  logic               cfg_wr,
    input  logic               cfg_en,
    input  logic               cfg_chime,
    input  logic [CODE_W-1:0]  cfg_code,
    input  logic [CNT_W-1:0]   cfg_rpt,
    input  logic               half_tick,
    input  logic               sec_tick,
    input  logic [FIELD_W-1:0] t_sec,
    input  logic [FIELD_W-1:0] t_min,
    input  logic [FIELD_W-1:0] t_hour,
    input  logic [FIELD_W-1:0] t_wday,
    input  logic [FIELD_W-1:0] t_day,
    input  logic [FIELD_W-1:0] t_mon,
    input  logic [FIELD_W-1:0] a_sec,
    input  logic [FIELD_W-1:0] a_min,
    input  logic [FIELD_W-1:0] a_hour,
    input  logic [FIELD_W-1:0] a_wday,
    input  logic [FIELD_W-1:0] a_day,
    input  logic [FIELD_W-1:0] a_mon,
    input  logic               pin_sel,
    output logic               alm_evt,
    output logic               alm_en,
    output logic [CNT_W-1:0]   rpt_cnt,
    output logic               alm_tgl,
    output logic               sec_clk,
    output logic               alm_pin
);
    alm_state_t        state_q;
    alm_state_t        state_d;
    logic              chime_q;
    logic [CODE_W-1:0] code_q;
    logic              hit;
    logic              spent;
    logic              in_fire;
    stamp_t            now_s;
    stamp_t            ref_s;

    assign now_s = '{mon: t_mon, day: t_day, wday: t_wday,
                     hour: t_hour, min: t_min, sec: t_sec};
    assign ref_s = '{mon: a_mon, day: a_day, wday: a_wday,
                     hour: a_hour, min: a_min, sec: a_sec};

    alarm_match u_match (
        .now_i     (now_s),
        .ref_i     (ref_s),
        .code_i    (code_q),
        .half_tick (half_tick),
        .sec_tick  (sec_tick),
        .hit_o     (hit)
    );

    alarm_repeat #(.CNT_W(CNT_W)) u_repeat (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (dev_rst),
        .load_i     (cfg_wr),
        .load_val_i (cfg_rpt),
        .step_i     (in_fire),
        .chime_i    (chime_q),
        .cnt_o      (rpt_cnt),
        .spent_o    (spent)
    );

    alarm_pin u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .sec_tick  (sec_tick),
        .flip_i    (in_fire),
        .sel_i     (pin_sel),
        .tgl_o     (alm_tgl),
        .secclk_o  (sec_clk),
        .pin_o     (alm_pin)
    );

    // configuration bits held beside the machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chime_q <= 1'b0;
            code_q  <= '0;
        end else if (dev_rst) begin
            chime_q <= 1'b0;
            code_q  <= '0;
        end else if (cfg_wr) begin
            chime_q <= cfg_chime;
            code_q  <= cfg_code;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (dev_rst) begin
            state_d = ST_OFF;
        end else if (cfg_wr) begin
            state_d = cfg_en ? ST_ARMED : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_OFF;
                ST_ARMED: state_d = hit ? ST_FIRE : ST_ARMED;
                ST_FIRE:  state_d = spent ? ST_OFF : ST_ARMED;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_fire = 1'b0;
        alm_en  = 1'b0;
        unique case (state_q)
            ST_OFF:   begin in_fire = 1'b0; alm_en = 1'b0; end
            ST_ARMED: begin in_fire = 1'b0; alm_en = 1'b1; end
            ST_FIRE:  begin in_fire = 1'b1; alm_en = 1'b1; end
            default:  begin in_fire = 1'b0; alm_en = 1'b0; end
        endcase
    end

    assign alm_evt = in_fire;

endmodule

// File: rtl/alarm_unit_chk.sv
module alarm_unit_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dev_rst,
    input logic             cfg_wr,
    input logic             alm_evt,
    input logic             alm_en,
    input logic [CNT_W-1:0] rpt_cnt,
    input logic             alm_tgl,
    input logic             chime,
    input logic [3:0]       mask
);
    // R4
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm_evt |=> !alm_evt);

    // R5
    last_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_evt && rpt_cnt == '0 && !chime && !cfg_wr && !dev_rst) |=> (!alm_en && rpt_cnt == '0));

    // R6
    chime_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_evt && rpt_cnt == '0 && chime && !cfg_wr && !dev_rst) |=> (alm_en && rpt_cnt == '1));

    // R7
    tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm_evt |=> (alm_tgl != $past(alm_tgl)));

    // R7
    tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alm_evt |=> $stable(alm_tgl));

    // R9
    dev_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> (!alm_en && rpt_cnt == '0));

    // R12
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_en && !cfg_wr) |=> !alm_evt);

    // R3
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask >= 4'd10) |=> !alm_evt);

endmodule

bind alarm_unit alarm_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dev_rst (dev_rst),
    .cfg_wr  (cfg_wr),
    .alm_evt (alm_evt),
    .alm_en  (alm_en),
    .rpt_cnt (rpt_cnt),
    .alm_tgl (alm_tgl),
    .chime   (chime_q),
    .mask    (code_q)
);

// File: tb/alarm_unit_test.sv
`timescale 1ns/1ps
module alarm_unit_test;
    logic clk = 0;
    logic rst_n = 0;
    logic dev_rst = 0, cfg_wr = 0, cfg_en = 0, cfg_chime = 0;
    logic [3:0] cfg_code = 0;
    logic [7:0] cfg_rpt = 0;
    logic half_tick = 0, sec_tick = 0, pin_sel = 0;
    logic [7:0] t_sec = 0, t_min = 0, t_hour = 0, t_wday = 0, t_day = 0, t_mon = 0;
    logic [7:0] a_sec = 0, a_min = 0, a_hour = 0, a_wday = 0, a_day = 0, a_mon = 0;
    logic alm_evt, alm_en, alm_tgl, sec_clk, alm_pin;
    logic [7:0] rpt_cnt;

    int vectors = 0, fails = 0, ev_n = 0;

    // behavioural reference state
    bit m_en, m_fire, m_chime, m_tgl, m_sclk;
    int m_code, m_cnt;

    always #4 clk = ~clk;

    alarm_unit uut (.*);

    function automatic bit ref_hit(int code);
        if (code > 9) return 0;
        if (code >= 2 && t_sec[3:0] != a_sec[3:0]) return 0;
        if (code >= 3 && t_sec[7:4] != a_sec[7:4]) return 0;
        if (code >= 4 && t_min[3:0] != a_min[3:0]) return 0;
        if (code >= 5 && t_min[7:4] != a_min[7:4]) return 0;
        if (code >= 6 && t_hour != a_hour) return 0;
        if (code == 7 && t_wday != a_wday) return 0;
        if (code >= 8 && t_day != a_day) return 0;
        if (code == 9 && t_mon != a_mon) return 0;
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_fire = 0; m_chime = 0; m_tgl = 0; m_sclk = 0;
            m_code = 0; m_cnt = 0;
        end else begin
            bit was_fire;
            bit strobe;
            was_fire = m_fire;
            strobe = (m_code == 0) ? half_tick : sec_tick;
            if (was_fire) m_tgl = !m_tgl;
            if (sec_tick) m_sclk = 0;
            else if (half_tick) m_sclk = 1;
            if (dev_rst) begin
                m_en = 0; m_fire = 0; m_chime = 0; m_code = 0; m_cnt = 0;
            end else if (cfg_wr) begin
                m_en = cfg_en; m_fire = 0; m_chime = cfg_chime;
                m_code = int'(cfg_code); m_cnt = int'(cfg_rpt);
            end else if (was_fire) begin
                m_fire = 0;
                if (m_cnt == 0 && !m_chime) m_en = 0;
                else m_cnt = (m_cnt + 255) % 256;
            end else if (m_en && strobe && ref_hit(m_code)) begin
                m_fire = 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (alm_evt) ev_n++;
            chk("R4 alm_evt", int'(alm_evt), int'(m_fire));
            chk("R5 alm_en", int'(alm_en), int'(m_en));
            chk("R5 rpt_cnt", int'(rpt_cnt), m_cnt);
            chk("R7 alm_tgl", int'(alm_tgl), int'(m_tgl));
            chk("R8 sec_clk", int'(sec_clk), int'(m_sclk));
            chk("R8 alm_pin", int'(alm_pin), int'(pin_sel ? m_sclk : m_tgl));
        end
    end

    task automatic load(input bit en, input bit ch, input int code, input int rpt);
        @(negedge clk);
        cfg_wr = 1; cfg_en = en; cfg_chime = ch; cfg_code = 4'(code); cfg_rpt = 8'(rpt);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic tick(input bit full);
        @(negedge clk);
        half_tick = 1; sec_tick = full;
        @(negedge clk);
        half_tick = 0; sec_tick = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_now_to_alarm();
        t_sec = a_sec; t_min = a_min; t_hour = a_hour;
        t_wday = a_wday; t_day = a_day; t_mon = a_mon;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int base;
        int tg;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 en", int'(alm_en), 0);
        chk("R1 evt", int'(alm_evt), 0);
        chk("R1 cnt", int'(rpt_cnt), 0);
        chk("R1 pin", int'(alm_pin), 0);
        rst_n = 1;
        @(negedge clk);

        // R12 disabled: matching strobes do nothing
        base = ev_n;
        a_sec = 8'h30; set_now_to_alarm();
        tick(1); tick(0);
        chk("R12 no event when off", ev_n - base, 0);

        // R10 load / R2 minute code, single shot (R5)
        load(1, 0, 3, 0);
        chk("R10 loaded en", int'(alm_en), 1);
        base = ev_n;
        for (int s = 28; s <= 32; s++) begin
            t_sec = 8'((s / 10) * 16 + s % 10);
            tick(1);
        end
        chk("R2 minute code one event", ev_n - base, 1);
        chk("R5 disabled after last", int'(alm_en), 0);

        // R5 ten-second code with count 2 -> three events
        a_sec = 8'h05;
        load(1, 0, 2, 2);
        chk("R10 loaded cnt", int'(rpt_cnt), 2);
        base = ev_n;
        for (int s = 0; s <= 35; s++) begin
            t_sec = 8'((s / 10) * 16 + s % 10);
            tick(1);
        end
        chk("R5 three events", ev_n - base, 3);
        chk("R5 off", int'(alm_en), 0);

        // R6 half-second with chime
        load(1, 1, 0, 1);
        base = ev_n;
        repeat (4) tick(0);
        chk("R6 four events", ev_n - base, 4);
        chk("R6 wrapped cnt", int'(rpt_cnt), 8'hFD);
        chk("R6 still enabled", int'(alm_en), 1);

        // R3 reserved codes
        for (int c = 10; c <= 15; c++) begin
            load(1, 0, c, 0);
            set_now_to_alarm();
            base = ev_n;
            tick(1); tick(0);
            chk("R3 reserved silent", ev_n - base, 0);
        end

        // R2 codes 4..9: inside-field change blocks, outside-field change fires
        a_sec = 8'h12; a_min = 8'h34; a_hour = 8'h08; a_wday = 8'h03; a_day = 8'h15; a_mon = 8'h06;
        for (int c = 4; c <= 9; c++) begin
            load(1, 0, c, 0);
            set_now_to_alarm();
            case (c)
                4: t_min = 8'h35;
                5: t_min = 8'h44;
                6: t_hour = 8'h09;
                7: t_wday = 8'h04;
                8: t_day = 8'h16;
                default: t_mon = 8'h07;
            endcase
            base = ev_n;
            tick(1);
            chk("R2 compared field blocks", ev_n - base, 0);
            set_now_to_alarm();
            case (c)
                4: t_min = 8'h44;
                5: t_hour = 8'h09;
                6: t_wday = 8'h05;
                7: t_day = 8'h20;
                8: t_wday = 8'h00;
                default: t_wday = 8'h06;
            endcase
            tick(1);
            chk("R2 ignored field fires", ev_n - base, 1);
        end

        // R11 yearly alarm on 02/29
        a_mon = 8'h02; a_day = 8'h29;
        load(1, 0, 9, 0);
        set_now_to_alarm();
        base = ev_n;
        t_day = 8'h28; tick(1);
        t_mon = 8'h03; t_day = 8'h01; tick(1);
        chk("R11 no fire off leap day", ev_n - base, 0);
        t_mon = 8'h02; t_day = 8'h29; tick(1);
        chk("R11 fires on 02/29", ev_n - base, 1);

        // R9 device reset keeps toggle
        load(1, 0, 1, 5);
        tick(1);
        tg = int'(alm_tgl);
        @(negedge clk); dev_rst = 1;
        @(negedge clk); dev_rst = 0;
        chk("R9 en cleared", int'(alm_en), 0);
        chk("R9 cnt cleared", int'(rpt_cnt), 0);
        chk("R9 tgl kept", int'(alm_tgl), tg);
        base = ev_n;
        tick(1);
        chk("R9 no event after", ev_n - base, 0);

        // R8 pin select
        pin_sel = 1;
        tick(0);
        chk("R8 pin high after half", int'(alm_pin), 1);
        tick(1);
        chk("R8 pin low after second", int'(alm_pin), 0);
        pin_sel = 0;
        @(negedge clk);
        chk("R8 pin follows toggle", int'(alm_pin), int'(alm_tgl));

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule